// File: doc/BRIEF.md
# Index-Data Configuration Access Port

This block gives a host a window into a banked set of configuration registers through only two byte addresses on an 8-bit internal I/O bus. The lower address of the pair holds a pointer (the Index register); the upper address is a data path that reads or writes whichever configuration register the pointer selects. Accesses last a single cycle and are marked by separate read and write strobes.

The place of the pair in the I/O space is fixed by a two-pin strap that is captured while the power-up reset is asserted. Two codes pick fixed pairs. One code takes the base from a 16-bit programmable value held in two global configuration registers. The last code places the part in a test mode in which no address responds. A later host-domain reset clears the pointer and the volatile registers but keeps the captured strap and the programmable base.

Index locations below 0x30 are global. Location 0x07 holds a logical-device number that selects which of several register banks is seen at 0x30 and above. Locations that do not exist read as 0xFF and ignore writes.

Top module: `cfg_port`

## Requirements
- R1: A write at base+0 stores the written byte as the Index value; a read at base+0 returns the last value written; the Index value is 0x00 after host-domain reset or power-up reset.
- R2: With strap code 00 the Index register is at 0x002E and the Data register at 0x002F; with strap code 01 they are at 0x004E and 0x004F. An address outside the selected pair does not respond.
- R3: With strap code 10 the Index register is at the programmable base and the Data register at base+1. The base high byte is global index 0x26 and the low byte index 0x27, both read/write through the Data register; a write that changes them moves the pair from the next cycle on. Their power-up value is 0x0164.
- R4: With strap code 11 the test_mode output is 1 and no address is decoded, so every read returns 0x00; with any other code test_mode is 0.
- R5: The strap inputs are captured only while por_n is low; later strap changes and host-domain resets leave the decoded address pair unchanged.
- R6: Index 0x07 is a read/write logical-device number; indices 0x30 to 0x3F address a register bank chosen by it, with separate storage for each of the four logical devices 0 to 3.
- R7: Index 0x20 reads the constant identification byte 0xD5 and ignores writes.
- R8: Reads at locations that do not exist (indices other than 0x07, 0x20, 0x26, 0x27 and 0x30 to 0x3F, or banked indices while the logical-device number is 4 or more) return 0xFF, and writes there change nothing.
- R9: rdata is 0x00 whenever rd_stb is low or the address is not decoded.
- R10: A host-domain reset (rst_n low) clears the Index value, the logical-device number and all bank registers, but keeps the programmable base and the captured strap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-up reset, synchronous, active low; captures the strap |
| rst_n | input | 1 | Host-domain reset, synchronous, active low |
| strap | input | 2 | Base-address strap inputs |
| addr | input | 16 | I/O byte address |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| test_mode | output | 1 | High when the strap selects test mode |

## Verification
The two functions that meet in one cycle are a Data-register write and the address decode that this write changes: with the programmable strap, writing the base low byte through the Data register relocates the very pair being used. The bench writes index 0x27 at the old Data address and then reads the Index register at the new base in the next cycle, expecting the old pointer value there and no response at the old address. A host-domain reset is also applied after the relocation to show the moved base survives it while the pointer returns to 0x00.

// File: rtl/cfg_port_pkg.sv
// Shared strap codes and fixed index locations of the configuration port.
// Assumes an 8-bit index space; indices below BANK_FIRST are global.
package cfg_port_pkg;
    typedef enum logic [1:0] {
        STRAP_LOW  = 2'b00,
        STRAP_HIGH = 2'b01,
        STRAP_PROG = 2'b10,
        STRAP_TEST = 2'b11
    } strap_mode_t;

    localparam logic [7:0] IX_LDN     = 8'h07;
    localparam logic [7:0] IX_CHIPID  = 8'h20;
    localparam logic [7:0] IX_BASE_HI = 8'h26;
    localparam logic [7:0] IX_BASE_LO = 8'h27;
    localparam logic [7:0] BANK_FIRST = 8'h30;
    localparam logic [7:0] NO_REG     = 8'hFF;
endpackage

// File: rtl/cfg_strap_latch.sv
// Captures the base-address strap while power-up reset is held.
// Assumes por_n is synchronous to clk; host-domain reset is not seen here.
module cfg_strap_latch
    import cfg_port_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  logic [1:0]  strap,
    output strap_mode_t mode
);
    // Follow the strap pins only during power-up reset, hold afterwards.
    always_ff @(posedge clk) begin
        if (!por_n) mode <= strap_mode_t'(strap);
    end
endmodule

// File: rtl/cfg_addr_decode.sv
// Compares the bus address against the strap-selected Index/Data pair.
// Assumes the Data register always sits one byte above the Index register.
module cfg_addr_decode
    import cfg_port_pkg::*;
#(
    parameter int            ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] LOW_BASE  = 16'h002E,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 16'h004E
) (
    input  strap_mode_t       mode,
    input  logic [ADDR_W-1:0] prog_base,
    input  logic [ADDR_W-1:0] addr,
    output logic              idx_sel,
    output logic              dat_sel
);
    logic [ADDR_W-1:0] base;
    logic              live;

    // Pick the active base for the captured strap code.
    always_comb begin
        live = 1'b1;
        unique case (mode)
            STRAP_LOW:  base = LOW_BASE;
            STRAP_HIGH: base = HIGH_BASE;
            STRAP_PROG: base = prog_base;
            default: begin
                base = '0;
                live = 1'b0;
            end
        endcase
    end

    // Match the address against base+0 and base+1.
    always_comb begin
        idx_sel = live && (addr == base);
        dat_sel = live && (addr == base + ADDR_W'(1));
    end
endmodule

// File: rtl/cfg_reg_file.sv
// Holds the Index pointer, the global registers and the banked registers.
// Assumes single-cycle strobes that are already qualified by address decode.
module cfg_reg_file
    import cfg_port_pkg::*;
#(
    parameter int          NUM_LDEV  = 4,
    parameter int          BANK_REGS = 16,
    parameter logic [15:0] PBASE_RST = 16'h0164,
    parameter logic [7:0]  CHIP_ID   = 8'hD5
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        host_rst_n,
    input  logic        idx_we,
    input  logic        dat_we,
    input  logic [7:0]  wdata,
    output logic [7:0]  idx_q,
    output logic [7:0]  dat_rdata,
    output logic [15:0] prog_base
);
    localparam int LDN_W = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;
    localparam int OFF_W = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1;

    logic [7:0]       ldn_q;
    logic [7:0]       off8;
    logic [OFF_W-1:0] off;
    logic             bank_hit;
    logic             bank_we;
    logic [7:0]       bank_rd [NUM_LDEV];

    // Index pointer: written at base+0, cleared by either reset.
    always_ff @(posedge clk) begin
        if (!host_rst_n)  idx_q <= 8'h00;
        else if (idx_we)  idx_q <= wdata;
    end

    // Logical-device number at its global index.
    always_ff @(posedge clk) begin
        if (!host_rst_n)                           ldn_q <= 8'h00;
        else if (dat_we && idx_q == IX_LDN)        ldn_q <= wdata;
    end

    // Programmable base bytes survive host-domain reset.
    always_ff @(posedge clk) begin
        if (!por_n) prog_base <= PBASE_RST;
        else if (dat_we && idx_q == IX_BASE_HI) prog_base[15:8] <= wdata;
        else if (dat_we && idx_q == IX_BASE_LO) prog_base[7:0]  <= wdata;
    end

    // Locate the current index inside the bank window.
    always_comb begin
        off8     = idx_q - BANK_FIRST;
        off      = off8[OFF_W-1:0];
        bank_hit = (idx_q >= BANK_FIRST) && (32'(off8) < BANK_REGS)
                   && (32'(ldn_q) < NUM_LDEV);
        bank_we  = dat_we && bank_hit;
    end

    for (genvar b = 0; b < NUM_LDEV; b++) begin : g_bank
        logic [7:0] regs [BANK_REGS];

        // One bank of registers, written when its device is selected.
        always_ff @(posedge clk) begin
            if (!host_rst_n) begin
                for (int i = 0; i < BANK_REGS; i++) regs[i] <= 8'h00;
            end else if (bank_we && ldn_q == 8'(b)) begin
                regs[off] <= wdata;
            end
        end

        assign bank_rd[b] = regs[off];
    end

    // Data-path read mux; missing locations read as all ones.
    always_comb begin
        if (bank_hit)                 dat_rdata = bank_rd[ldn_q[LDN_W-1:0]];
        else if (idx_q == IX_LDN)     dat_rdata = ldn_q;
        else if (idx_q == IX_CHIPID)  dat_rdata = CHIP_ID;
        else if (idx_q == IX_BASE_HI) dat_rdata = prog_base[15:8];
        else if (idx_q == IX_BASE_LO) dat_rdata = prog_base[7:0];
        else                          dat_rdata = NO_REG;
    end
endmodule

// File: rtl/cfg_port.sv
// Top of the Index/Data configuration access port.
// Assumes single-cycle bus strobes; rdata is combinational in the read cycle.
module cfg_port
    import cfg_port_pkg::*;
#(
    parameter int          NUM_LDEV  = 4,
    parameter int          BANK_REGS = 16,
    parameter logic [15:0] PBASE_RST = 16'h0164,
    parameter logic [7:0]  CHIP_ID   = 8'hD5
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic [1:0]  strap,
    input  logic [15:0] addr,
    input  logic        wr_stb,
    input  logic        rd_stb,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        test_mode
);
    strap_mode_t mode;
    logic [15:0] prog_base;
    logic        idx_sel;
    logic        dat_sel;
    logic [7:0]  idx_q;
    logic [7:0]  dat_rdata;
    logic        host_rst_n;

    assign host_rst_n = rst_n && por_n;
    assign test_mode  = (mode == STRAP_TEST);

    cfg_strap_latch u_strap (
        .clk   (clk),
        .por_n (por_n),
        .strap (strap),
        .mode  (mode)
    );

    cfg_addr_decode #(.ADDR_W(16)) u_dec (
        .mode      (mode),
        .prog_base (prog_base),
        .addr      (addr),
        .idx_sel   (idx_sel),
        .dat_sel   (dat_sel)
    );

    cfg_reg_file #(
        .NUM_LDEV  (NUM_LDEV),
        .BANK_REGS (BANK_REGS),
        .PBASE_RST (PBASE_RST),
        .CHIP_ID   (CHIP_ID)
    ) u_rf (
        .clk        (clk),
        .por_n      (por_n),
        .host_rst_n (host_rst_n),
        .idx_we     (wr_stb && idx_sel),
        .dat_we     (wr_stb && dat_sel),
        .wdata      (wdata),
        .idx_q      (idx_q),
        .dat_rdata  (dat_rdata),
        .prog_base  (prog_base)
    );

    // Return data only for a decoded read, zero otherwise.
    always_comb begin
        if (rd_stb && idx_sel)      rdata = idx_q;
        else if (rd_stb && dat_sel) rdata = dat_rdata;
        else                        rdata = 8'h00;
    end
endmodule

// File: rtl/cfg_port_sva.sv
// Checker for cfg_port, attached by bind; observes ports and decode outputs.
module cfg_port_sva (
    input logic       clk,
    input logic       por_n,
    input logic       rst_n,
    input logic       rd_stb,
    input logic       wr_stb,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       test_mode,
    input logic       idx_sel,
    input logic       dat_sel,
    input logic [7:0] idx_q,
    input logic [1:0] mode
);
    // R1: a reset leaves the pointer at zero in the next cycle.
    p_idx_clear_r1: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> idx_q == 8'h00);

    // R1: a decoded Index write is stored.
    p_idx_write_r1: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (wr_stb && idx_sel) |=> idx_q == $past(wdata));

    // R5: the captured strap holds once power-up reset is released.
    p_strap_hold_r5: assert property (@(posedge clk) disable iff (!por_n)
        $past(por_n) |-> $stable(mode));

    // R4: nothing answers in test mode.
    p_test_quiet_r4: assert property (@(posedge clk) disable iff (!por_n)
        test_mode |-> (rdata == 8'h00 && !idx_sel && !dat_sel));

    // R9: idle bus returns zero.
    p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!por_n)
        !rd_stb |-> rdata == 8'h00);

    // R8: indices past the bank window read all ones.
    p_no_reg_r8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (rd_stb && dat_sel && idx_q >= 8'h40) |-> rdata == 8'hFF);

    // R2: the two decode outputs never fire together.
    p_one_sel_r2: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({idx_sel, dat_sel}));
endmodule

bind cfg_port cfg_port_sva u_sva (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .wdata     (wdata),
    .rdata     (rdata),
    .test_mode (test_mode),
    .idx_sel   (idx_sel),
    .dat_sel   (dat_sel),
    .idx_q     (idx_q),
    .mode      (mode)
);

// File: tb/cfg_port_test.sv
// Directed bench for cfg_port: inputs change on the falling edge,
// outputs are read mid-low-phase, before the next rising edge.
module cfg_port_test;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  strap = 2'b00;
    logic [15:0] addr = 16'h0000;
    logic        wr_stb = 1'b0;
    logic        rd_stb = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        test_mode;

    int checks = 0;
    int errors = 0;

    cfg_port uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .strap(strap),
        .addr(addr), .wr_stb(wr_stb), .rd_stb(rd_stb), .wdata(wdata),
        .rdata(rdata), .test_mode(test_mode)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_stb = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic cfg_rd(input logic [15:0] b, input logic [7:0] ix, output logic [7:0] d);
        bus_wr(b, ix);
        bus_rd(b + 16'd1, d);
    endtask

    task automatic cfg_wr(input logic [15:0] b, input logic [7:0] ix, input logic [7:0] d);
        bus_wr(b, ix);
        bus_wr(b + 16'd1, d);
    endtask

    task automatic power_up(input logic [1:0] s);
        @(negedge clk);
        por_n = 1'b0; rst_n = 1'b1; strap = s;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic host_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1 R2 R4 R9: reset state and pointer storage at the low pair.
    task automatic t_index_low();
        logic [7:0] d;
        power_up(2'b00);
        check("R4 test_mode low", {7'd0, test_mode}, 8'h00);
        bus_rd(16'h002E, d); check("R1 index after power-up", d, 8'h00);
        bus_wr(16'h002E, 8'h5A);
        bus_rd(16'h002E, d); check("R1 index readback", d, 8'h5A);
        bus_rd(16'h004E, d); check("R2 other pair silent", d, 8'h00);
        @(negedge clk); addr = 16'h002E; #1;
        check("R9 idle rdata", rdata, 8'h00);
    endtask

    // R7 R8: fixed ID and locations that do not exist.
    task automatic t_globals();
        logic [7:0] d;
        cfg_rd(16'h002E, 8'h20, d); check("R7 chip id", d, 8'hD5);
        cfg_wr(16'h002E, 8'h20, 8'h11);
        cfg_rd(16'h002E, 8'h20, d); check("R7 id ignores write", d, 8'hD5);
        cfg_wr(16'h002E, 8'h45, 8'h33);
        cfg_rd(16'h002E, 8'h45, d); check("R8 index 0x45 reads FF", d, 8'hFF);
        cfg_rd(16'h002E, 8'h10, d); check("R8 index 0x10 reads FF", d, 8'hFF);
    endtask

    // R6 R8: separate storage per logical device.
    task automatic t_banks();
        logic [7:0] d;
        cfg_wr(16'h002E, 8'h07, 8'h00); cfg_wr(16'h002E, 8'h30, 8'hA0);
        cfg_wr(16'h002E, 8'h07, 8'h01); cfg_wr(16'h002E, 8'h30, 8'hB1);
        cfg_wr(16'h002E, 8'h07, 8'h03); cfg_wr(16'h002E, 8'h3F, 8'hC3);
        cfg_rd(16'h002E, 8'h07, d); check("R6 ldn readback", d, 8'h03);
        cfg_rd(16'h002E, 8'h3F, d); check("R6 bank3 top reg", d, 8'hC3);
        cfg_wr(16'h002E, 8'h07, 8'h00);
        cfg_rd(16'h002E, 8'h30, d); check("R6 bank0 reg", d, 8'hA0);
        cfg_wr(16'h002E, 8'h07, 8'h01);
        cfg_rd(16'h002E, 8'h30, d); check("R6 bank1 reg", d, 8'hB1);
        cfg_wr(16'h002E, 8'h07, 8'h05);
        cfg_rd(16'h002E, 8'h30, d); check("R8 missing device reads FF", d, 8'hFF);
        cfg_wr(16'h002E, 8'h30, 8'h77);
        cfg_wr(16'h002E, 8'h07, 8'h01);
        cfg_rd(16'h002E, 8'h30, d); check("R8 write to missing device ignored", d, 8'hB1);
    endtask

    // R10 R5: host reset clears volatile state, strap stays.
    task automatic t_host_reset();
        logic [7:0] d;
        bus_wr(16'h002E, 8'h30);
        strap = 2'b01;
        host_reset();
        bus_rd(16'h002E, d); check("R10 index cleared", d, 8'h00);
        bus_rd(16'h004E, d); check("R5 strap change ignored", d, 8'h00);
        cfg_rd(16'h002E, 8'h07, d); check("R10 ldn cleared", d, 8'h00);
        cfg_rd(16'h002E, 8'h30, d); check("R10 bank cleared", d, 8'h00);
    endtask

    // R2: high pair after a new power-up.
    task automatic t_index_high();
        logic [7:0] d;
        power_up(2'b01);
        bus_wr(16'h004E, 8'h20);
        bus_rd(16'h004F, d); check("R2 high pair data", d, 8'hD5);
        bus_rd(16'h002E, d); check("R2 low pair silent", d, 8'h00);
    endtask

    // R3 R10: programmable base, relocation and survival over host reset.
    task automatic t_prog_base();
        logic [7:0] d;
        power_up(2'b10);
        cfg_rd(16'h0164, 8'h26, d); check("R3 base high reset", d, 8'h01);
        cfg_rd(16'h0164, 8'h27, d); check("R3 base low reset", d, 8'h64);
        bus_wr(16'h0165, 8'h80);
        bus_rd(16'h0180, d); check("R3 moved pair keeps index", d, 8'h27);
        bus_rd(16'h0164, d); check("R3 old pair silent", d, 8'h00);
        bus_wr(16'h0180, 8'h26); bus_wr(16'h0181, 8'h03);
        bus_rd(16'h0380, d); check("R3 high byte moves pair", d, 8'h26);
        host_reset();
        bus_rd(16'h0380, d); check("R10 base kept, index cleared", d, 8'h00);
    endtask

    // R4: test mode decodes nothing; leaving it restores decode.
    task automatic t_test_mode();
        logic [7:0] d;
        power_up(2'b11);
        check("R4 test_mode high", {7'd0, test_mode}, 8'h01);
        bus_rd(16'h002E, d); check("R4 0x2E silent", d, 8'h00);
        bus_rd(16'h004E, d); check("R4 0x4E silent", d, 8'h00);
        bus_rd(16'h0164, d); check("R4 0x164 silent", d, 8'h00);
        power_up(2'b00);
        check("R4 test_mode cleared", {7'd0, test_mode}, 8'h00);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_index_low();
        t_globals();
        t_banks();
        t_host_reset();
        t_index_high();
        t_prog_base();
        t_test_mode();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule